// File: doc/BRIEF.md
# Linear CCD Clock Timing Generator

This block drives a three-colour linear CCD whose every colour is read through two in-phase outputs (odd and even pixels). From one system clock and tick counters it makes the transfer-gate pulse, the two-phase shift clocks, the last-stage clock, the reset gate clock and the clamp clock. It also gives downstream capture logic a pixel index, a region code and a strobe at the sampling point of each pixel period. All durations are counts of the system clock. They are loaded as one set through a write strobe and take effect only between lines.

A line begins with a pulse on `line_start`. The shift clocks hold their transfer state for a guard time, the transfer gate opens, the guard time follows again, and then a programmable number of pixel periods is read out. Two clamp regimes are offered. In bit clamp, the reset and clamp pulses run every pixel period, including through the transfer window. In line clamp, the reset gate is held high across the window and one clamp pulse is placed after the transfer gate closes.

Top module: `ccd_line_timer`

## Requirements
- R1: During reset, `xfer_gate`, `shift_b`, `reset_gate`, `clamp`, `pix_strobe` and `cfg_error` are 0, `shift_a` and `shift_last` are 1, and `pix_region` is 0.
- R2: An accepted start gives, in order: a guard hold of `cfg_guard_w` cycles, `xfer_gate` high for exactly `cfg_xfer_w` cycles, a second guard of `cfg_guard_w` cycles, and `cfg_line_len` pixel periods of `cfg_pix_per` cycles each. The block then goes idle.
- R3: `pix_strobe` pulses once per pixel period, `cfg_pix_per/2` cycles into it. The first strobe comes `cfg_guard_w + cfg_pix_per/2` cycles after `xfer_gate` falls. `pix_index` runs from 0 to `cfg_line_len-1`. `pix_region` is 1 (optical black) for index below 96, 2 (dummy) for 96..101 and for 7402 and above, and 3 (valid) for 102..7401. `pix_region` is 0 while no readout is running.
- R4: Outside readout, including the whole transfer window, `shift_a`=1 and `shift_b`=0. During readout, `shift_a` is high for the first half of each pixel period and `shift_b` is its complement. `shift_last` always equals `shift_a`. The two shift clocks are never high together.
- R5: A loaded set raises `cfg_error` if any of these holds: transfer width below 600 cycles, guard below 180, pixel period below 4, reset or clamp width 0, reset plus clamp width above half the pixel period, line-clamp gap below 20, line-clamp width below 40, gap plus line-clamp width above the guard, or line length 0. While `cfg_error` is 1, `line_start` is ignored.
- R6: Bit clamp (`cfg_bit_clamp`=1): `reset_gate` is high for the first `cfg_rst_w` cycles of every pixel period. `clamp` is high for the next `cfg_clp_w` cycles. Both keep running through the transfer window, and they are never high together.
- R7: Line clamp (`cfg_bit_clamp`=0): `reset_gate` is high through both guards and the transfer pulse. `clamp` is a single pulse of `cfg_lc_w` cycles that rises `cfg_lc_gap` cycles after `xfer_gate` falls, and it is never high while `xfer_gate` is high.
- R8: A `cfg_wr` while a line is in progress is ignored. The running line and the following lines keep the old values, and `cfg_error` does not change.
- R9: `line_start` while a line is in progress is ignored: no second transfer pulse and no extra pixels.
- R10: If `cfg_wr` and `line_start` come in the same idle cycle, the write is taken and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Start-of-line request |
| cfg_wr | input | 1 | Load strobe for all cfg_* values |
| cfg_bit_clamp | input | 1 | 1 selects bit clamp, 0 selects line clamp |
| cfg_xfer_w | input | 16 | Transfer pulse width, cycles |
| cfg_guard_w | input | 16 | Shift hold before and after the transfer pulse, cycles |
| cfg_pix_per | input | 16 | Pixel period per output, cycles |
| cfg_rst_w | input | 16 | Reset gate pulse width, cycles |
| cfg_clp_w | input | 16 | Bit-clamp pulse width, cycles |
| cfg_lc_gap | input | 16 | Delay from transfer fall to line-clamp rise, cycles |
| cfg_lc_w | input | 16 | Line-clamp pulse width, cycles |
| cfg_line_len | input | 14 | Pixel periods per line |
| xfer_gate | output | 1 | Transfer-gate pulse |
| shift_a | output | 1 | Shift clock phase 1 |
| shift_b | output | 1 | Shift clock phase 2 |
| shift_last | output | 1 | Last-stage clock |
| reset_gate | output | 1 | Reset gate clock |
| clamp | output | 1 | Clamp clock |
| pix_strobe | output | 1 | Sampling-point strobe |
| pix_index | output | 14 | Pixel index within the line |
| pix_region | output | 2 | Region code of the current pixel |
| cfg_error | output | 1 | Loaded timing set breaks a minimum |

## Verification
A configuration write and a start request can land in the same idle cycle, and the block has to settle which one wins. The bench asserts both strobes on one edge with a new, legal set. It then checks that no transfer pulse follows, that `cfg_error` reflects the new values, and that the next separate start runs with the new pixel period and length. The same pairing inside a running line is driven too, with an illegal set. That line must complete unchanged, `cfg_error` must stay low, and the following line must still use the old widths.

// File: rtl/ccd_tg_pkg.sv
`timescale 1ns/1ps
package ccd_tg_pkg;
    localparam int DW = 16;
    localparam int LW = 14;

    typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_XFER, ST_POST, ST_READ} seq_e;
    typedef enum logic [1:0] {RG_NONE = 2'd0, RG_BLACK = 2'd1, RG_DUMMY = 2'd2, RG_VALID = 2'd3} region_e;

    typedef struct packed {
        logic          bit_clamp;
        logic [DW-1:0] xfer_w;
        logic [DW-1:0] guard_w;
        logic [DW-1:0] pix_per;
        logic [DW-1:0] rst_w;
        logic [DW-1:0] clp_w;
        logic [DW-1:0] lc_gap;
        logic [DW-1:0] lc_w;
        logic [LW-1:0] line_len;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        bit_clamp: 1'b1,
        xfer_w:    DW'(2000),
        guard_w:   DW'(300),
        pix_per:   DW'(8),
        rst_w:     DW'(1),
        clp_w:     DW'(1),
        lc_gap:    DW'(40),
        lc_w:      DW'(200),
        line_len:  LW'(7438)
    };
endpackage

// File: rtl/ccd_tg_cfg.sv
`timescale 1ns/1ps
module ccd_tg_cfg
    import ccd_tg_pkg::*;
#(
    parameter int MIN_XFER   = 600,
    parameter int MIN_GUARD  = 180,
    parameter int MIN_PIX    = 4,
    parameter int MIN_LC_GAP = 20,
    parameter int MIN_LC_W   = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic idle,
    input  cfg_t wdata,
    output cfg_t cfg,
    output logic err
);
    typedef struct packed {
        cfg_t cfg;
        logic err;
    } cfg_state_t;

    cfg_state_t q, d;
    logic       bad;
    logic [DW:0] bc_sum, lc_sum;

    always_comb begin
        bc_sum = {1'b0, wdata.rst_w} + {1'b0, wdata.clp_w};
        lc_sum = {1'b0, wdata.lc_gap} + {1'b0, wdata.lc_w};
        bad = (wdata.xfer_w  < DW'(MIN_XFER))
            | (wdata.guard_w < DW'(MIN_GUARD))
            | (wdata.pix_per < DW'(MIN_PIX))
            | (wdata.rst_w == '0)
            | (wdata.clp_w == '0)
            | (bc_sum > {2'b00, wdata.pix_per[DW-1:1]})
            | (wdata.lc_gap < DW'(MIN_LC_GAP))
            | (wdata.lc_w   < DW'(MIN_LC_W))
            | (lc_sum > {1'b0, wdata.guard_w})
            | (wdata.line_len == '0);
        d = q;
        if (wr && idle) begin
            d.cfg = wdata;
            d.err = bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg <= CFG_RESET;
            q.err <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cfg = q.cfg;
    assign err = q.err;
endmodule

// File: rtl/ccd_tg_seq.sv
`timescale 1ns/1ps
module ccd_tg_seq
    import ccd_tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          cfg_wr,
    input  logic          cfg_error,
    input  cfg_t          cfg,
    output seq_e          st,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] ph,
    output logic [LW-1:0] pix
);
    typedef struct packed {
        seq_e          st;
        logic [DW-1:0] cnt;
        logic [DW-1:0] ph;
        logic [LW-1:0] pix;
    } seq_state_t;

    seq_state_t    q, d;
    logic          ph_wrap, start_ok;
    logic [DW-1:0] ph_nx, cnt_nx;

    always_comb begin
        ph_wrap  = (q.ph >= cfg.pix_per - DW'(1));
        ph_nx    = ph_wrap ? '0 : q.ph + DW'(1);
        cnt_nx   = q.cnt + DW'(1);
        start_ok = line_start && !cfg_wr && !cfg_error;
        d        = q;
        d.ph     = ph_nx;
        unique case (q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    d.st  = ST_PRE;
                    d.cnt = '0;
                    d.ph  = '0;
                end
            end
            ST_PRE: begin
                d.cnt = cnt_nx;
                if (q.cnt >= cfg.guard_w - DW'(1)) begin
                    d.st  = ST_XFER;
                    d.cnt = '0;
                end
            end
            ST_XFER: begin
                d.cnt = cnt_nx;
                if (q.cnt >= cfg.xfer_w - DW'(1)) begin
                    d.st  = ST_POST;
                    d.cnt = '0;
                end
            end
            ST_POST: begin
                d.cnt = cnt_nx;
                if (q.cnt >= cfg.guard_w - DW'(1)) begin
                    d.st  = ST_READ;
                    d.cnt = '0;
                    d.ph  = '0;
                    d.pix = '0;
                end
            end
            ST_READ: begin
                if (ph_wrap) begin
                    if (q.pix >= cfg.line_len - LW'(1)) d.st = ST_IDLE;
                    else                                d.pix = q.pix + LW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.cnt <= '0;
            q.ph  <= '0;
            q.pix <= '0;
        end else begin
            q <= d;
        end
    end

    assign st  = q.st;
    assign cnt = q.cnt;
    assign ph  = q.ph;
    assign pix = q.pix;
endmodule

// File: rtl/ccd_tg_wave.sv
`timescale 1ns/1ps
module ccd_tg_wave
    import ccd_tg_pkg::*;
#(
    parameter int OB_PIX    = 96,
    parameter int LEAD_PIX  = 6,
    parameter int VALID_PIX = 7300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_e          st,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] ph,
    input  logic [LW-1:0] pix,
    input  cfg_t          cfg,
    output logic          xfer_gate,
    output logic          shift_a,
    output logic          shift_b,
    output logic          shift_last,
    output logic          reset_gate,
    output logic          clamp,
    output logic          pix_strobe,
    output logic [LW-1:0] pix_index,
    output logic [1:0]    pix_region
);
    localparam logic [LW-1:0] VALID_LO = LW'(OB_PIX + LEAD_PIX);
    localparam logic [LW-1:0] VALID_HI = LW'(OB_PIX + LEAD_PIX + VALID_PIX);
    localparam logic [LW-1:0] BLACK_HI = LW'(OB_PIX);

    typedef struct packed {
        logic          xg;
        logic          sa;
        logic          sb;
        logic          rg;
        logic          cl;
        logic          stb;
        logic [LW-1:0] idx;
        region_e       rgn;
    } wave_t;

    wave_t         q, d;
    logic [DW-1:0] half;
    logic [DW:0]   bc_end, lc_end;
    logic          in_win, reading, first_half;

    always_comb begin
        half       = {1'b0, cfg.pix_per[DW-1:1]};
        bc_end     = {1'b0, cfg.rst_w} + {1'b0, cfg.clp_w};
        lc_end     = {1'b0, cfg.lc_gap} + {1'b0, cfg.lc_w};
        in_win     = (st == ST_PRE) || (st == ST_XFER) || (st == ST_POST);
        reading    = (st == ST_READ);
        first_half = (ph < half);

        d      = q;
        d.xg   = (st == ST_XFER);
        d.sa   = reading ? first_half : 1'b1;
        d.sb   = reading ? !first_half : 1'b0;
        if (cfg.bit_clamp) begin
            d.rg = (ph < cfg.rst_w);
            d.cl = (ph >= cfg.rst_w) && ({1'b0, ph} < bc_end);
        end else begin
            d.rg = in_win ? 1'b1 : (ph < cfg.rst_w);
            d.cl = (st == ST_POST) && (cnt >= cfg.lc_gap) && ({1'b0, cnt} < lc_end);
        end
        d.stb  = reading && (ph == half);
        d.idx  = pix;
        if (!reading)             d.rgn = RG_NONE;
        else if (pix < BLACK_HI)  d.rgn = RG_BLACK;
        else if (pix < VALID_LO)  d.rgn = RG_DUMMY;
        else if (pix < VALID_HI)  d.rgn = RG_VALID;
        else                      d.rgn = RG_DUMMY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.xg  <= 1'b0;
            q.sa  <= 1'b1;
            q.sb  <= 1'b0;
            q.rg  <= 1'b0;
            q.cl  <= 1'b0;
            q.stb <= 1'b0;
            q.idx <= '0;
            q.rgn <= RG_NONE;
        end else begin
            q <= d;
        end
    end

    assign xfer_gate  = q.xg;
    assign shift_a    = q.sa;
    assign shift_b    = q.sb;
    assign shift_last = q.sa;
    assign reset_gate = q.rg;
    assign clamp      = q.cl;
    assign pix_strobe = q.stb;
    assign pix_index  = q.idx;
    assign pix_region = q.rgn;
endmodule

// File: rtl/ccd_line_timer.sv
`timescale 1ns/1ps
module ccd_line_timer
    import ccd_tg_pkg::*;
#(
    parameter int MIN_XFER   = 600,
    parameter int MIN_GUARD  = 180,
    parameter int MIN_PIX    = 4,
    parameter int MIN_LC_GAP = 20,
    parameter int MIN_LC_W   = 40,
    parameter int OB_PIX     = 96,
    parameter int LEAD_PIX   = 6,
    parameter int VALID_PIX  = 7300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          cfg_wr,
    input  logic          cfg_bit_clamp,
    input  logic [15:0]   cfg_xfer_w,
    input  logic [15:0]   cfg_guard_w,
    input  logic [15:0]   cfg_pix_per,
    input  logic [15:0]   cfg_rst_w,
    input  logic [15:0]   cfg_clp_w,
    input  logic [15:0]   cfg_lc_gap,
    input  logic [15:0]   cfg_lc_w,
    input  logic [13:0]   cfg_line_len,
    output logic          xfer_gate,
    output logic          shift_a,
    output logic          shift_b,
    output logic          shift_last,
    output logic          reset_gate,
    output logic          clamp,
    output logic          pix_strobe,
    output logic [13:0]   pix_index,
    output logic [1:0]    pix_region,
    output logic          cfg_error
);
    cfg_t          wr_cfg, cur_cfg;
    seq_e          seq_st;
    logic [DW-1:0] seq_cnt, seq_ph;
    logic [LW-1:0] seq_pix;

    always_comb begin
        wr_cfg.bit_clamp = cfg_bit_clamp;
        wr_cfg.xfer_w    = cfg_xfer_w;
        wr_cfg.guard_w   = cfg_guard_w;
        wr_cfg.pix_per   = cfg_pix_per;
        wr_cfg.rst_w     = cfg_rst_w;
        wr_cfg.clp_w     = cfg_clp_w;
        wr_cfg.lc_gap    = cfg_lc_gap;
        wr_cfg.lc_w      = cfg_lc_w;
        wr_cfg.line_len  = cfg_line_len;
    end

    ccd_tg_cfg #(
        .MIN_XFER  (MIN_XFER),
        .MIN_GUARD (MIN_GUARD),
        .MIN_PIX   (MIN_PIX),
        .MIN_LC_GAP(MIN_LC_GAP),
        .MIN_LC_W  (MIN_LC_W)
    ) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (cfg_wr),
        .idle (seq_st == ST_IDLE),
        .wdata(wr_cfg),
        .cfg  (cur_cfg),
        .err  (cfg_error)
    );

    ccd_tg_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .cfg_wr    (cfg_wr),
        .cfg_error (cfg_error),
        .cfg       (cur_cfg),
        .st        (seq_st),
        .cnt       (seq_cnt),
        .ph        (seq_ph),
        .pix       (seq_pix)
    );

    ccd_tg_wave #(
        .OB_PIX   (OB_PIX),
        .LEAD_PIX (LEAD_PIX),
        .VALID_PIX(VALID_PIX)
    ) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (seq_st),
        .cnt       (seq_cnt),
        .ph        (seq_ph),
        .pix       (seq_pix),
        .cfg       (cur_cfg),
        .xfer_gate (xfer_gate),
        .shift_a   (shift_a),
        .shift_b   (shift_b),
        .shift_last(shift_last),
        .reset_gate(reset_gate),
        .clamp     (clamp),
        .pix_strobe(pix_strobe),
        .pix_index (pix_index),
        .pix_region(pix_region)
    );
endmodule

// File: rtl/ccd_line_timer_chk.sv
`timescale 1ns/1ps
module ccd_line_timer_chk #(
    parameter int MIN_XFER = 600
) (
    input logic       clk,
    input logic       rst_n,
    input logic       xfer_gate,
    input logic       shift_a,
    input logic       shift_b,
    input logic       shift_last,
    input logic       reset_gate,
    input logic       clamp,
    input logic       pix_strobe,
    input logic [1:0] pix_region,
    input logic       bit_mode
);
    logic [31:0] xlen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         xlen <= '0;
        else if (xfer_gate) xlen <= xlen + 32'd1;
        else                xlen <= '0;
    end

    // R2
    xfer_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_gate) |-> (xlen >= 32'(MIN_XFER)));

    // R4
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_gate |-> (shift_a && !shift_b && shift_last));

    // R4
    shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_a && shift_b));

    // R6
    bit_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_mode |-> !(reset_gate && clamp));

    // R7
    line_rg_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_mode && xfer_gate) |-> reset_gate);

    // R7
    line_clamp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_mode && clamp) |-> !xfer_gate);

    // R3
    strobe_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_strobe |-> (pix_region != 2'd0 && !xfer_gate));
endmodule

bind ccd_line_timer ccd_line_timer_chk #(.MIN_XFER(MIN_XFER)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_gate (xfer_gate),
    .shift_a   (shift_a),
    .shift_b   (shift_b),
    .shift_last(shift_last),
    .reset_gate(reset_gate),
    .clamp     (clamp),
    .pix_strobe(pix_strobe),
    .pix_region(pix_region),
    .bit_mode  (cur_cfg.bit_clamp)
);

// File: tb/tb_ccd_line_timer.sv
`timescale 1ns/1ps
module tb_ccd_line_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_bit_clamp = 1'b1;
    logic [15:0] cfg_xfer_w = '0, cfg_guard_w = '0, cfg_pix_per = '0, cfg_rst_w = '0;
    logic [15:0] cfg_clp_w = '0, cfg_lc_gap = '0, cfg_lc_w = '0;
    logic [13:0] cfg_line_len = '0;
    logic        xfer_gate, shift_a, shift_b, shift_last, reset_gate, clamp, pix_strobe, cfg_error;
    logic [13:0] pix_index;
    logic [1:0]  pix_region;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ccd_line_timer dut (.*);

    function automatic void check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    // scoreboard of expected {index, region}
    int exp_q[$];

    function automatic int region_of(int i);
        if (i < 96)   return 1;
        if (i < 102)  return 2;
        if (i < 7402) return 3;
        return 2;
    endfunction

    task automatic push_line(int len);
        for (int i = 0; i < len; i++) exp_q.push_back(i * 4 + region_of(i));
    endtask

    // monitor state
    int tg_pulses, tg_len, held_viol, rs_low_tg, rs_rise_tg, cp_in_tg;
    int cp_cnt, cp_off, since_fall, strobe_off, strobe_cnt, ovl, last_rgn;
    bit fall_seen, prev_xg, prev_rg, prev_cp;

    task automatic clear_mon();
        tg_pulses = 0; tg_len = 0; held_viol = 0; rs_low_tg = 0; rs_rise_tg = 0;
        cp_in_tg = 0; cp_cnt = 0; cp_off = -1; since_fall = 0; strobe_off = -1;
        strobe_cnt = 0; ovl = 0; fall_seen = 0; last_rgn = -1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_gate) begin
                if (!prev_xg) begin tg_pulses++; tg_len = 0; end
                tg_len++;
                if (!(shift_a && !shift_b && shift_last)) held_viol++;
                if (!reset_gate) rs_low_tg++;
                if (reset_gate && !prev_rg) rs_rise_tg++;
                if (clamp) cp_in_tg++;
            end
            if (!xfer_gate && prev_xg) begin since_fall = 0; fall_seen = 1; end
            else if (fall_seen) since_fall++;
            if (clamp) cp_cnt++;
            if (clamp && !prev_cp && fall_seen && cp_off < 0) cp_off = since_fall;
            if (reset_gate && clamp) ovl++;
            if (pix_strobe) begin
                if (strobe_cnt == 0) strobe_off = since_fall;
                strobe_cnt++;
                last_rgn = pix_region;
                if (exp_q.size() == 0) check(0, "R3 unexpected strobe", pix_index, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(pix_index == 14'(e / 4), "R3 pixel index", pix_index, e / 4);
                    check(pix_region == 2'(e % 4), "R3 region code", pix_region, e % 4);
                end
            end
            prev_xg = xfer_gate; prev_rg = reset_gate; prev_cp = clamp;
        end
    end

    task automatic write_cfg(bit bm, int xw, int gw, int pp, int rw, int cw,
                             int gap, int lw, int len, bit with_start);
        @(posedge clk); #1;
        cfg_bit_clamp = bm; cfg_xfer_w = 16'(xw); cfg_guard_w = 16'(gw);
        cfg_pix_per = 16'(pp); cfg_rst_w = 16'(rw); cfg_clp_w = 16'(cw);
        cfg_lc_gap = 16'(gap); cfg_lc_w = 16'(lw); cfg_line_len = 14'(len);
        cfg_wr = 1'b1; line_start = with_start;
        @(posedge clk); #1;
        cfg_wr = 1'b0; line_start = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 line_start = 1'b1;
        @(posedge clk); #1 line_start = 1'b0;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        clear_mon();
        prev_xg = 0; prev_rg = 0; prev_cp = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!xfer_gate && shift_a && !shift_b && shift_last, "R1 shift/xfer at reset", {xfer_gate, shift_a, shift_b}, 3'b010);
        check(!reset_gate && !clamp && !pix_strobe, "R1 pulses at reset", {reset_gate, clamp, pix_strobe}, 0);
        check(pix_region == 2'd0 && !cfg_error, "R1 region/error at reset", {pix_region, cfg_error}, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // bit clamp line, with start and bad write injected mid-line
        write_cfg(1, 620, 190, 8, 1, 2, 20, 40, 110, 0);
        @(negedge clk);
        check(!cfg_error, "R5 legal set accepted", cfg_error, 0);
        clear_mon(); push_line(110);
        pulse_start();
        wait_cycles(300);
        write_cfg(1, 100, 190, 8, 1, 2, 20, 40, 5, 1);   // R8 R9 mid-line write and start
        wait_cycles(380 + 620 + 880 + 20);
        check(tg_pulses == 1, "R9 one transfer pulse", tg_pulses, 1);
        check(tg_len == 620, "R2 transfer width", tg_len, 620);
        check(strobe_cnt == 110, "R2 pixel count", strobe_cnt, 110);
        check(strobe_off == 194, "R3 first strobe offset", strobe_off, 194);
        check(held_viol == 0, "R4 shift hold in window", held_viol, 0);
        check(rs_rise_tg > 0, "R6 reset pulses in window", rs_rise_tg, 1);
        check(cp_in_tg > 0, "R6 clamp pulses in window", cp_in_tg, 1);
        check(ovl == 0, "R6 reset/clamp overlap", ovl, 0);
        check(!cfg_error, "R8 error unchanged by mid-line write", cfg_error, 0);

        // R8 next line keeps old set
        clear_mon(); push_line(110);
        pulse_start();
        wait_cycles(380 + 620 + 880 + 20);
        check(tg_len == 620, "R8 old transfer width kept", tg_len, 620);
        check(strobe_cnt == 110, "R8 old line length kept", strobe_cnt, 110);

        // line clamp line
        write_cfg(0, 700, 200, 6, 1, 1, 25, 50, 105, 0);
        clear_mon(); push_line(105);
        pulse_start();
        wait_cycles(400 + 700 + 630 + 20);
        check(tg_len == 700, "R2 transfer width line mode", tg_len, 700);
        check(rs_low_tg == 0, "R7 reset held in window", rs_low_tg, 0);
        check(cp_cnt == 50, "R7 clamp width", cp_cnt, 50);
        check(cp_off == 25, "R7 clamp offset", cp_off, 25);
        check(cp_in_tg == 0, "R7 clamp off during transfer", cp_in_tg, 0);
        check(strobe_off == 203, "R3 first strobe offset line mode", strobe_off, 203);
        check(strobe_cnt == 105, "R2 pixel count line mode", strobe_cnt, 105);

        // R5 illegal set blocks start
        write_cfg(1, 100, 190, 8, 1, 1, 20, 40, 50, 0);
        @(negedge clk);
        check(cfg_error, "R5 short transfer flagged", cfg_error, 1);
        clear_mon();
        pulse_start();
        wait_cycles(2000);
        check(tg_pulses == 0, "R5 start ignored on error", tg_pulses, 0);
        write_cfg(1, 600, 180, 4, 1, 2, 20, 40, 50, 0);
        @(negedge clk);
        check(cfg_error, "R5 reset+clamp beyond half period flagged", cfg_error, 1);

        // R10 write and start together
        clear_mon();
        write_cfg(1, 600, 180, 4, 1, 1, 20, 40, 7410, 1);
        wait_cycles(1500);
        check(tg_pulses == 0, "R10 start dropped on write", tg_pulses, 0);
        check(!cfg_error, "R10 write taken", cfg_error, 0);

        // long line reaching trailing dummy
        clear_mon(); push_line(7410);
        pulse_start();
        wait_cycles(360 + 600 + 29640 + 40);
        check(strobe_cnt == 7410, "R3 long line count", strobe_cnt, 7410);
        check(last_rgn == 2, "R3 trailing dummy region", last_rgn, 2);
        check(tg_len == 600, "R2 transfer width at minimum", tg_len, 600);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        @(negedge clk);
        check(pix_region == 2'd0, "R3 region idle", pix_region, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule